// File: doc/BRIEF.md
# SMBus Slave Command Engine

This block is the byte-level half of an SMBus slave. It samples SCL and SDA with a system clock that runs much faster than the bus. It detects START, STOP and bit edges, and it walks through the four short transaction shapes: write-byte, read-byte, send-byte and receive-byte. Toward the bus it has a single open-drain enable: when `sda_oe` is high, SDA is pulled low. It uses that enable both for acknowledge bits and for the bits of a read byte. Toward the rest of the chip it drives three things: write strobes into a small register file, single-cycle pulses for two one-shot commands, and a read pointer that the register file decodes into `rd_data`.

The engine answers two addresses: the 7-bit address on `own_addr`, and the alert-response address. It answers the alert-response address only for a read, and only while `alert_pend` is high. It then returns its own address and pulses `alert_clr`. An 8-bit command pointer is kept across transactions, so a receive-byte returns the register that the last write-byte or read-byte selected. A transaction cut short by START or STOP in the middle of a byte leaves no trace. A data byte aimed at a command that is not a plain data register is written to register 0.

Top module: `smb_cmd_engine`

## Requirements
- R1: After reset, `sda_oe`, `wr_en`, `resample_pulse`, `swreset_pulse` and `alert_clr` are low, and the command pointer is 0x00, so a receive-byte returns register 0.
- R2: An address byte is the 7-bit address followed by the R/W bit in the LSB (1 = read), sent MSB first. The engine acknowledges it by pulling SDA low on the ninth clock only when the 7 address bits equal `own_addr`. Any other address gets no acknowledge and produces no strobe.
- R3: A write-byte (address with R/W=0, command byte, data byte) produces one `wr_en` pulse carrying the data byte on `wr_data`. The pulse follows the falling SCL edge of the data byte's ninth clock and comes before the STOP.
- R4: Command codes 0x00 to 0x05 are data registers, and a write to one of them strobes that index on `wr_idx`. A data byte sent with any other command, such as 0x06 (pin status), 0x07, 0x08 or 0xFE (ID), strobes `wr_idx` = 0.
- R5: Command 0x07 pulses `resample_pulse` and command 0x08 pulses `swreset_pulse`, once each time the command byte completes. This happens whether the command comes as a send-byte or as the first byte of a write-byte. One-shot codes do not change the command pointer.
- R6: A read-byte (write address, command, repeated START, read address) and a receive-byte both return one byte, MSB first. When the pointer is 0xFE the byte is the constant 0x4D. For any other pointer it is `rd_data`, with `rd_ptr` holding the pointer; for example, code 0x06 returns the pin status that the register file presents.
- R7: A START or STOP that arrives before a byte is complete aborts the transaction. The partial byte causes no write strobe, no one-shot pulse and no pointer change. Bytes that completed earlier in the same transaction keep their effect.
- R8: A read to the alert-response address 0x0C (byte 0x19) is acknowledged only while `alert_pend` is high. It returns `{own_addr, 1'b0}` and pulses `alert_clr` once. A write to that address is not acknowledged.
- R9: After the single read byte, the engine releases SDA whether the master acknowledges or not. It drives nothing more until the next START, so any further clocks read 0xFF.
- R10: In a write transaction, a third byte after the address is not acknowledged and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL level from the pad |
| sda_in | input | 1 | SDA level from the pad |
| own_addr | input | 7 | The slave's own 7-bit address |
| alert_pend | input | 1 | An interrupt is pending; enables the alert-response reply |
| rd_data | input | 8 | Register file read data for `rd_ptr` |
| sda_oe | output | 1 | High pulls SDA low |
| rd_ptr | output | 8 | Current command pointer (read select) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_idx | output | 3 | Register index of the write |
| wr_data | output | 8 | Data of the write |
| resample_pulse | output | 1 | One-cycle pulse for command 0x07 |
| swreset_pulse | output | 1 | One-cycle pulse for command 0x08 |
| alert_clr | output | 1 | One-cycle pulse after an alert-response reply |

## Verification
The hardest case to reach from the ports is an abort in the middle of a byte that follows a byte which has already committed. The pointer must keep the completed command, while the cut-off data byte must leave no strobe. Reaching it takes a bench master built from single-bit tasks, so that a transaction can be stopped after any chosen number of bits with a START or STOP. The bench also holds a pointer in a known state, fires a one-shot command, and then reads back with a receive-byte. That sequence shows that the pointer survives one-shot codes, which no single transaction can show.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          NREG       = 6;
    localparam int          RIDX_W     = $clog2(NREG);
    localparam int          CNT_W      = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    localparam logic [7:0]  CMD_RESAMPLE = 8'h07;
    localparam logic [7:0]  CMD_SWRESET  = 8'h08;
    localparam logic [7:0]  CMD_ID       = 8'hFE;
    localparam logic [7:0]  ID_VALUE     = 8'h4D;
    localparam logic [6:0]  ARA_ADDR     = 7'h0C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_WAIT
    } eng_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic             en;
        logic [RIDX_W-1:0] idx;
        logic [7:0]       data;
    } wr_req_t;

    function automatic logic [RIDX_W-1:0] wr_target(input logic [7:0] cmd);
        if (cmd < 8'(NREG)) return cmd[RIDX_W-1:0];
        return '0;
    endfunction

    function automatic logic is_oneshot(input logic [7:0] cmd);
        return (cmd == CMD_RESAMPLE) || (cmd == CMD_SWRESET);
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt,
    output logic     scl_lvl
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q[g] <= 1'b1;
                    sda_q[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_q[g] <= scl_in;
                    sda_q[g] <= sda_in;
                end else begin
                    scl_q[g] <= scl_q[(g == 0) ? 0 : g-1];
                    sda_q[g] <= sda_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    always_comb begin
        evt.sda   = sda_q[STAGES-1];
        evt.rise  = scl_q[STAGES-1] & ~scl_d;
        evt.fall  = ~scl_q[STAGES-1] & scl_d;
        evt.start = scl_q[STAGES-1] & scl_d & sda_d & ~sda_q[STAGES-1];
        evt.stop  = scl_q[STAGES-1] & scl_d & ~sda_d & sda_q[STAGES-1];
    end

    assign scl_lvl = scl_q[STAGES-1];

endmodule

// File: rtl/smb_tx_mux.sv
module smb_tx_mux
    import smb_pkg::*;
(
    input  logic [7:0] ptr,
    input  logic       ara_sel,
    input  logic [6:0] own_addr,
    input  logic [7:0] rd_data,
    output logic [7:0] tx_byte
);

    always_comb begin
        if (ara_sel)
            tx_byte = {own_addr, 1'b0};
        else if (ptr == CMD_ID)
            tx_byte = ID_VALUE;
        else
            tx_byte = rd_data;
    end

endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm
    import smb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bus_evt_t    evt,
    input  logic [6:0]  own_addr,
    input  logic        alert_pend,
    input  logic [7:0]  tx_byte,
    output logic        sda_oe,
    output logic [7:0]  ptr,
    output logic        ara_sel,
    output wr_req_t     wr,
    output logic        resample_pulse,
    output logic        swreset_pulse,
    output logic        alert_clr
);

    eng_state_t       state;
    logic [CNT_W-1:0] bitcnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic             rw;
    logic [1:0]       nbytes;
    logic [7:0]       cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_IDLE;
            bitcnt         <= '0;
            rx_sh          <= '0;
            tx_sh          <= '0;
            rw             <= 1'b0;
            nbytes         <= '0;
            cmd_q          <= '0;
            ptr            <= '0;
            ara_sel        <= 1'b0;
            sda_oe         <= 1'b0;
            wr             <= '0;
            resample_pulse <= 1'b0;
            swreset_pulse  <= 1'b0;
            alert_clr      <= 1'b0;
        end else begin
            wr.en          <= 1'b0;
            resample_pulse <= 1'b0;
            swreset_pulse  <= 1'b0;
            alert_clr      <= 1'b0;
            if (evt.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                nbytes <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (evt.rise && bitcnt < LAST_BIT) begin
                            rx_sh  <= {rx_sh[6:0], evt.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.fall && bitcnt == LAST_BIT) begin
                            if (rx_sh[7:1] == own_addr) begin
                                rw      <= rx_sh[0];
                                ara_sel <= 1'b0;
                                sda_oe  <= 1'b1;
                                state   <= ST_AACK;
                            end else if (rx_sh[7:1] == ARA_ADDR && rx_sh[0] && alert_pend) begin
                                rw      <= 1'b1;
                                ara_sel <= 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_AACK;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (evt.fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                tx_sh     <= tx_byte;
                                sda_oe    <= ~tx_byte[7];
                                alert_clr <= ara_sel;
                                state     <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_RX: begin
                        if (evt.rise && bitcnt < LAST_BIT) begin
                            rx_sh  <= {rx_sh[6:0], evt.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.fall && bitcnt == LAST_BIT) begin
                            if (nbytes < 2'd2) begin
                                sda_oe <= 1'b1;
                                state  <= ST_RACK;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            nbytes <= nbytes + 2'd1;
                            state  <= ST_RX;
                            if (nbytes == 2'd0) begin
                                cmd_q <= rx_sh;
                                if (is_oneshot(rx_sh)) begin
                                    resample_pulse <= (rx_sh == CMD_RESAMPLE);
                                    swreset_pulse  <= (rx_sh == CMD_SWRESET);
                                end else begin
                                    ptr <= rx_sh;
                                end
                            end else begin
                                wr.en   <= 1'b1;
                                wr.idx  <= wr_target(cmd_q);
                                wr.data <= rx_sh;
                            end
                        end
                    end
                    ST_TX: begin
                        if (evt.rise && bitcnt < LAST_BIT) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.fall && bitcnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WAIT;
                        end else if (evt.fall && bitcnt != '0) begin
                            tx_sh  <= {tx_sh[6:0], 1'b0};
                            sda_oe <= ~tx_sh[6];
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_cmd_engine.sv
module smb_cmd_engine
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [6:0]        own_addr,
    input  logic              alert_pend,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic [7:0]        rd_ptr,
    output logic              wr_en,
    output logic [RIDX_W-1:0] wr_idx,
    output logic [7:0]        wr_data,
    output logic              resample_pulse,
    output logic              swreset_pulse,
    output logic              alert_clr
);

    bus_evt_t   bus_evt;
    logic       scl_lvl;
    logic       scl_fall_seen;
    logic       ara_sel;
    logic [7:0] tx_byte;
    wr_req_t    wr;

    smb_line_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .evt     (bus_evt),
        .scl_lvl (scl_lvl)
    );

    smb_tx_mux u_txmux (
        .ptr      (rd_ptr),
        .ara_sel  (ara_sel),
        .own_addr (own_addr),
        .rd_data  (rd_data),
        .tx_byte  (tx_byte)
    );

    smb_byte_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .evt            (bus_evt),
        .own_addr       (own_addr),
        .alert_pend     (alert_pend),
        .tx_byte        (tx_byte),
        .sda_oe         (sda_oe),
        .ptr            (rd_ptr),
        .ara_sel        (ara_sel),
        .wr             (wr),
        .resample_pulse (resample_pulse),
        .swreset_pulse  (swreset_pulse),
        .alert_clr      (alert_clr)
    );

    assign wr_en         = wr.en;
    assign wr_idx        = wr.idx;
    assign wr_data       = wr.data;
    assign scl_fall_seen = bus_evt.fall;

endmodule

// File: rtl/smb_cmd_engine_chk.sv
module smb_cmd_engine_chk
    import smb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [RIDX_W-1:0] wr_idx,
    input logic              resample_pulse,
    input logic              swreset_pulse,
    input logic              alert_clr,
    input logic              scl_lvl,
    input logic              scl_fall_seen
);

    // R1: outputs quiet on the cycle after a reset cycle
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && !wr_en && !resample_pulse && !swreset_pulse && !alert_clr));

    // R3: a write strobe follows a detected SCL falling edge
    a_r3_wr_after_fall: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(scl_fall_seen));

    // R3 / R5 / R8: the commit pulses come from distinct clock edges, never together
    a_r5_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, resample_pulse, swreset_pulse, alert_clr}));

    // R4: write index always names an existing data register
    a_r4_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx < RIDX_W'(NREG)));

    // R9: SDA drive only changes while the synchronised SCL is low
    a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl));

endmodule

bind smb_cmd_engine smb_cmd_engine_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .sda_oe         (sda_oe),
    .wr_en          (wr_en),
    .wr_idx         (wr_idx),
    .resample_pulse (resample_pulse),
    .swreset_pulse  (swreset_pulse),
    .alert_clr      (alert_clr),
    .scl_lvl        (scl_lvl),
    .scl_fall_seen  (scl_fall_seen)
);

// File: tb/test_smb_cmd_engine.sv
module test_smb_cmd_engine;
    import smb_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst = 1'b1;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic [6:0]        own = 7'h2A;
    logic              alert_pend = 1'b0;
    logic [7:0]        rd_data;
    logic              sda_oe;
    logic [7:0]        rd_ptr;
    logic              wr_en;
    logic [RIDX_W-1:0] wr_idx;
    logic [7:0]        wr_data;
    logic              resample_pulse, swreset_pulse, alert_clr;
    logic              sda_line;
    logic [7:0]        pin_stat = 8'hC3;

    assign sda_line = sda_m & ~sda_oe;

    smb_cmd_engine i_smb_cmd_engine (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .own_addr(own), .alert_pend(alert_pend), .rd_data(rd_data),
        .sda_oe(sda_oe), .rd_ptr(rd_ptr), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .resample_pulse(resample_pulse),
        .swreset_pulse(swreset_pulse), .alert_clr(alert_clr)
    );

    // environment register file
    logic [7:0] regs [NREG];
    initial for (int i = 0; i < NREG; i++) regs[i] = 8'(8'h11 * (i + 1));
    always @(posedge clk) if (wr_en) regs[wr_idx] <= wr_data;
    always_comb begin
        if (rd_ptr < 8'(NREG)) rd_data = regs[rd_ptr[RIDX_W-1:0]];
        else if (rd_ptr == 8'h06) rd_data = pin_stat;
        else rd_data = 8'h00;
    end

    // expected register contents, tracked from the requirements
    logic [7:0] expv [NREG];
    initial for (int i = 0; i < NREG; i++) expv[i] = 8'(8'h11 * (i + 1));

    int wr_cnt = 0, rs_cnt = 0, sw_cnt = 0, ac_cnt = 0;
    logic [RIDX_W-1:0] last_idx;
    logic [7:0]        last_dat;
    always @(negedge clk) if (!rst) begin
        if (wr_en) begin wr_cnt++; last_idx = wr_idx; last_dat = wr_data; end
        if (resample_pulse) rs_cnt++;
        if (swreset_pulse) sw_cnt++;
        if (alert_clr) ac_cnt++;
    end

    int n_vec = 0, n_bad = 0;
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (8) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
    endtask

    task automatic bstop();
        sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b; hp(); scl_m = 1'b1;
        repeat (4) @(negedge clk); seen = sda_line;
        repeat (4) @(negedge clk); scl_m = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic get_byte(input logic m_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
        clk_bit(!m_ack, s);
    endtask

    task automatic rx_txn(input logic [6:0] a, output logic [7:0] v, output logic ok);
        bstart(); put_byte({a, 1'b1}, ok); get_byte(1'b0, v); bstop();
    endtask

    task automatic rd_txn(input logic [7:0] cmd, output logic [7:0] v, output logic ok);
        logic a1, a2, a3;
        bstart(); put_byte({own, 1'b0}, a1); put_byte(cmd, a2);
        bstart(); put_byte({own, 1'b1}, a3); get_byte(1'b0, v); bstop();
        ok = a1 & a2 & a3;
    endtask

    // returns write count sampled after the data ACK and before the STOP
    task automatic wr_txn(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                          output logic ok, output int cnt_before_stop);
        logic a1, a2, a3;
        bstart(); put_byte({a, 1'b0}, a1); put_byte(cmd, a2); put_byte(d, a3);
        cnt_before_stop = wr_cnt;
        bstop();
        ok = a1 & a2 & a3;
    endtask

    logic [7:0] codes [10] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'hFE};

    initial begin
        logic ok, a1, a2;
        logic [7:0] v;
        int w0, wb, r0, s0;

        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 sda_oe in reset", sda_oe, 0);
        chk("R1 wr_en in reset", wr_en, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 pulses after reset", {resample_pulse, swreset_pulse, alert_clr}, 0);

        // R1 receive-byte right after reset returns register 0
        rx_txn(own, v, ok);
        chk("R2 own read ack", ok, 1);
        chk("R1 pointer 0 after reset", v, expv[0]);

        // R3 R4 R5 write sweep over every command code
        for (int k = 0; k < 10; k++) begin
            logic [7:0] c, d;
            logic [RIDX_W-1:0] tgt;
            c = codes[k];
            d = 8'h3C ^ 8'(c * 8'd37);
            tgt = (c < 8'd6) ? c[RIDX_W-1:0] : '0;
            w0 = wr_cnt; r0 = rs_cnt; s0 = sw_cnt;
            wr_txn(own, c, d, ok, wb);
            chk("R2 write acks", ok, 1);
            chk("R3 strobe before STOP", wb, w0 + 1);
            chk("R3 single strobe", wr_cnt, w0 + 1);
            chk("R4 target index", last_idx, tgt);
            chk("R3 data", last_dat, d);
            chk("R5 resample count", rs_cnt - r0, (c == 8'h07) ? 1 : 0);
            chk("R5 swreset count", sw_cnt - s0, (c == 8'h08) ? 1 : 0);
            expv[tgt] = d;
        end

        // R6 read-byte sweep plus receive-byte reuse of the pointer
        for (int k = 0; k < 10; k++) begin
            logic [7:0] c, e;
            c = codes[k];
            if (c == 8'h07 || c == 8'h08) continue;
            e = (c == 8'hFE) ? 8'h4D : (c == 8'h06) ? pin_stat : expv[c[RIDX_W-1:0]];
            rd_txn(c, v, ok);
            chk("R6 read-byte acks", ok, 1);
            chk("R6 read-byte value", v, e);
            rx_txn(own, v, ok);
            chk("R6 receive-byte reuse", v, e);
        end

        // R5 one-shot keeps the pointer
        wr_txn(own, 8'h03, 8'h5A, ok, wb); expv[3] = 8'h5A;
        w0 = wr_cnt; s0 = sw_cnt;
        bstart(); put_byte({own, 1'b0}, a1); put_byte(8'h08, a2); bstop();
        chk("R5 send-byte swreset pulse", sw_cnt - s0, 1);
        chk("R5 send-byte no strobe", wr_cnt, w0);
        rx_txn(own, v, ok);
        chk("R5 pointer kept after one-shot", v, 8'h5A);
        r0 = rs_cnt;
        bstart(); put_byte({own, 1'b0}, a1); put_byte(8'h07, a2); bstop();
        chk("R5 send-byte resample pulse", rs_cnt - r0, 1);

        // R7 abort inside the data byte: command kept, data discarded
        w0 = wr_cnt;
        bstart(); put_byte({own, 1'b0}, a1); put_byte(8'h02, a2);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, ok);
        bstart(); bstop();
        chk("R7 no strobe on partial data", wr_cnt, w0);
        rx_txn(own, v, ok);
        chk("R7 completed command kept", v, expv[2]);
        // R7 abort inside the command byte
        r0 = rs_cnt;
        bstart(); put_byte({own, 1'b0}, a1);
        for (int i = 0; i < 5; i++) clk_bit(1'b0, ok);
        bstop();
        rx_txn(own, v, ok);
        chk("R7 pointer untouched by partial command", v, expv[2]);
        chk("R7 no one-shot on partial command", rs_cnt, r0);

        // R2 foreign addresses and an address change
        w0 = wr_cnt;
        wr_txn(own ^ 7'h01, 8'h01, 8'hEE, ok, wb);
        chk("R2 foreign write nack", ok, 0);
        chk("R2 foreign write no strobe", wr_cnt, w0);
        own = 7'h55;
        bstart(); put_byte({7'h2A, 1'b1}, a1); bstop();
        chk("R2 old address nack", a1, 0);
        wr_txn(own, 8'h01, 8'h77, ok, wb); expv[1] = 8'h77;
        chk("R2 new address write", ok, 1);
        chk("R3 new address data", last_dat, 8'h77);

        // R8 alert response
        bstart(); put_byte({ARA_ADDR, 1'b1}, a1); bstop();
        chk("R8 no reply without pending alert", a1, 0);
        alert_pend = 1'b1;
        bstart(); put_byte({ARA_ADDR, 1'b0}, a1); bstop();
        chk("R8 write to alert address nack", a1, 0);
        s0 = ac_cnt;
        rx_txn(ARA_ADDR, v, ok);
        chk("R8 alert address ack", ok, 1);
        chk("R8 returns own address", v, {own, 1'b0});
        chk("R8 alert_clr pulse", ac_cnt - s0, 1);
        alert_pend = 1'b0;

        // R9 SDA released after the read byte, master ACKs then clocks on
        bstart(); put_byte({own, 1'b1}, a1); get_byte(1'b1, v); get_byte(1'b0, v); bstop();
        chk("R9 no drive after read byte", v, 8'hFF);

        // R10 third byte of a write is refused
        w0 = wr_cnt;
        bstart(); put_byte({own, 1'b0}, a1); put_byte(8'h04, a2); put_byte(8'h90, ok);
        put_byte(8'h91, ok); bstop(); expv[4] = 8'h90;
        chk("R10 third byte nack", ok, 0);
        chk("R10 only one strobe", wr_cnt, w0 + 1);
        rd_txn(8'h04, v, ok);
        chk("R10 register holds second byte", v, 8'h90);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule